// File: doc/BRIEF.md
# Host-to-Coprocessor Command Mailbox

This block is a single-channel, memory-mapped mailbox between a host processor and a secure coprocessor. The host fills sixteen 32-bit argument registers through a word-addressed register bus, then writes a command word. That write moves the command and a copy of all sixteen arguments into a four-entry queue as one unit. The host can then reuse the argument registers at once, and the queued entry does not change.

The coprocessor takes queued commands, oldest first, through a valid/pop handshake. It reports each finished command with a done pulse that carries a result code and sixteen status words. The mailbox latches these words into read-only result registers for the host. A command holds its queue slot from the moment it is written until it is completed, so the count the host sees includes commands that are still in service.

Three events raise interrupt flags: command completion, a rejected command write on a full queue, and the queue becoming full. Each flag is cleared by writing 1 to it. Each flag has a mask bit, where 1 means masked. A single level interrupt output is high while any unmasked flag is set.

Top module: `cmd_mailbox`

## Requirements
- R1: Sixteen argument words are writable and readable at byte offsets 0x00 + 4*i (i = 0..15). Reset clears them to zero.
- R2: A write to offset 0x40 with fewer than four commands held enqueues the command. cp_cmd_valid_o is high while a held command has not yet been popped, and the commands are presented in write order on cp_cmd_o and cp_args_o. Argument i sits at bits [32*i+31:32*i].
- R3: The queue status word at offset 0xC4 reports the number of held commands (0..4) in bits 2:0 and cp_ready_i in bit 8. All other bits are 0.
- R4: A write to offset 0x40 while four commands are held is discarded, and the held commands are unchanged. The write sets interrupt flag bit 17, even when a completion happens in the same cycle.
- R5: Interrupt flag bit 18 is set when an accepted command write brings the count to four.
- R6: A completion (cp_done_i with at least one popped command not yet completed) does three things in the same cycle. It loads cp_retcode_i into offset 0x80 and status word i into offset 0x84 + 4*i. It decrements the count. It sets interrupt flag bit 0.
- R7: The interrupt flag register at offset 0xC8 holds bits 0, 17 and 18 and reads zero elsewhere. Writing 1 to a bit clears it. If the same bit's event occurs in the same cycle, the event wins.
- R8: The mask register at offset 0xCC holds bits 0, 17 and 18, where 1 means masked, and resets to 0x00060001. irq_o is high exactly when some flag bit is set and its mask bit is 0.
- R9: Read data is registered: rdata_o shows the addressed word in the cycle after rd_i. Unmapped or unaligned addresses read 0. Writes to read-only offsets have no effect.
- R10: A command's arguments are the values held in the argument registers when its command word was written. Argument writes made after that do not alter it.
- R11: cp_pop_i is ignored when no unpopped command is held. cp_done_i is ignored when no popped command awaits completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Byte address of the register access |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Host interrupt, level |
| cp_ready_i | input | 1 | Coprocessor ready indication |
| cp_cmd_valid_o | output | 1 | An unpopped command is presented |
| cp_cmd_o | output | 32 | Command word of the presented command |
| cp_args_o | output | 512 | Arguments of the presented command |
| cp_pop_i | input | 1 | Coprocessor takes the presented command |
| cp_done_i | input | 1 | Coprocessor completes the oldest popped command |
| cp_retcode_i | input | 32 | Result code for the completion |
| cp_status_i | input | 512 | Sixteen status words for the completion |

## Verification
The bench targets four cases. The first is a command written while the queue is full, both on its own and together with a completion in the same cycle. A design that used the post-completion count there would accept the write instead of raising the reject flag. The second is argument rewrites between commands, which would show up on the coprocessor side as corrupted arguments if the queue referenced the live registers instead of a copy. The third is a clear of the completion flag in the same cycle as a new completion, which must leave the flag set. The fourth is pops and done pulses with nothing eligible, which must change neither the count nor the presented command. Masked and unmasked interrupt states are followed on every clock against a behavioural queue model.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned DW       = 32;
  localparam int unsigned AW       = 8;
  localparam int unsigned NUM_ARGS = 16;
  localparam int unsigned NUM_STAT = 16;

  // word offsets (byte offset / 4)
  localparam int unsigned W_CMD   = 16;
  localparam int unsigned W_RET   = 32;
  localparam int unsigned W_STAT0 = 33;
  localparam int unsigned W_QSTAT = 49;
  localparam int unsigned W_FLAGS = 50;
  localparam int unsigned W_MASK  = 51;

  localparam int unsigned BIT_DONE  = 0;
  localparam int unsigned BIT_DROP  = 17;
  localparam int unsigned BIT_FULL  = 18;
  localparam int unsigned BIT_READY = 8;

  typedef struct packed {
    logic full;
    logic drop;
    logic done;
  } irq_vec_t;

  function automatic logic [DW-1:0] irq_to_word(irq_vec_t v);
    logic [DW-1:0] w;
    w           = '0;
    w[BIT_DONE] = v.done;
    w[BIT_DROP] = v.drop;
    w[BIT_FULL] = v.full;
    return w;
  endfunction
endpackage

// File: rtl/mbox_cmd_queue.sv
module mbox_cmd_queue #(
  parameter int unsigned DW       = 32,
  parameter int unsigned NUM_ARGS = 16,
  parameter int unsigned DEPTH    = 4,
  localparam int unsigned CW      = $clog2(DEPTH + 1),
  localparam int unsigned PW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   push_i,
  input  logic [DW-1:0]          cmd_i,
  input  logic [NUM_ARGS*DW-1:0] args_i,
  input  logic                   pop_i,
  input  logic                   done_i,
  output logic [CW-1:0]          count_o,
  output logic                   drop_o,
  output logic                   full_set_o,
  output logic                   done_ok_o,
  output logic                   head_valid_o,
  output logic [DW-1:0]          head_cmd_o,
  output logic [NUM_ARGS*DW-1:0] head_args_o
);
  logic [DW-1:0]          cmd_mem [DEPTH];
  logic [NUM_ARGS*DW-1:0] arg_mem [DEPTH];
  logic [PW-1:0]          wr_ptr_q, iss_ptr_q;
  logic [CW-1:0]          count_q, svc_q, count_nxt, svc_nxt;
  logic                   accept, pop_ok, done_ok;

  function automatic logic [PW-1:0] ptr_inc(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // count covers popped-but-incomplete entries; slot freed only on completion
  assign accept    = push_i && (count_q != CW'(DEPTH));
  assign drop_o    = push_i && (count_q == CW'(DEPTH));
  assign pop_ok    = pop_i && (count_q > svc_q);
  assign done_ok   = done_i && (svc_q != '0);
  assign count_nxt = count_q + CW'(accept) - CW'(done_ok);
  assign svc_nxt   = svc_q + CW'(pop_ok) - CW'(done_ok);

  assign full_set_o   = accept && (count_nxt == CW'(DEPTH));
  assign done_ok_o    = done_ok;
  assign count_o      = count_q;
  assign head_valid_o = count_q > svc_q;
  assign head_cmd_o   = cmd_mem[iss_ptr_q];
  assign head_args_o  = arg_mem[iss_ptr_q];

  always_ff @(posedge clk_i) begin
    if (accept) begin
      cmd_mem[wr_ptr_q] <= cmd_i;
      arg_mem[wr_ptr_q] <= args_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q  <= '0;
      iss_ptr_q <= '0;
      count_q   <= '0;
      svc_q     <= '0;
    end else begin
      if (accept) wr_ptr_q  <= ptr_inc(wr_ptr_q);
      if (pop_ok) iss_ptr_q <= ptr_inc(iss_ptr_q);
      count_q <= count_nxt;
      svc_q   <= svc_nxt;
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  assert_drop_keeps_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && count_q == CW'(DEPTH) && !done_ok) |=> count_q == CW'(DEPTH));
  assert_full_reached_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_set_o |=> count_q == CW'(DEPTH));
  assert_svc_le_count_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_q <= count_q);
endmodule

// File: rtl/mbox_result_regs.sv
module mbox_result_regs #(
  parameter int unsigned DW       = 32,
  parameter int unsigned NUM_STAT = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   load_i,
  input  logic [DW-1:0]          ret_i,
  input  logic [NUM_STAT*DW-1:0] stat_i,
  output logic [DW-1:0]          ret_o,
  output logic [NUM_STAT*DW-1:0] stat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ret_o  <= '0;
      stat_o <= '0;
    end else if (load_i) begin
      ret_o  <= ret_i;
      stat_o <= stat_i;
    end
  end

  assert_capture_ret_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ret_o == $past(ret_i));
  assert_hold_ret_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(ret_o));
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
  import mbox_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  irq_vec_t ev_i,
  input  logic     clr_we_i,
  input  irq_vec_t clr_i,
  input  logic     mask_we_i,
  input  irq_vec_t mask_i,
  output irq_vec_t flags_o,
  output irq_vec_t mask_o,
  output logic     irq_o
);
  irq_vec_t flags_q, mask_q, clr_eff;

  assign clr_eff = clr_we_i ? clr_i : irq_vec_t'('0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      mask_q  <= '1;
    end else begin
      flags_q <= irq_vec_t'((flags_q & ~clr_eff) | ev_i); // event wins over clear
      if (mask_we_i) mask_q <= mask_i;
    end
  end

  assign flags_o = flags_q;
  assign mask_o  = mask_q;
  assign irq_o   = |(flags_q & ~mask_q);

  assert_done_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.done |=> flags_q.done);
  assert_drop_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.drop |=> flags_q.drop);
  assert_w1c_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && clr_i.done && !ev_i.done) |=> !flags_q.done);
  assert_masked_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == irq_vec_t'('1)) |-> !irq_o);
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import mbox_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned WAW  = AW - 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [AW-1:0]          addr_i,
  input  logic                   wr_i,
  input  logic                   rd_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o,
  output logic                   irq_o,
  input  logic                   cp_ready_i,
  output logic                   cp_cmd_valid_o,
  output logic [DW-1:0]          cp_cmd_o,
  output logic [NUM_ARGS*DW-1:0] cp_args_o,
  input  logic                   cp_pop_i,
  input  logic                   cp_done_i,
  input  logic [DW-1:0]          cp_retcode_i,
  input  logic [NUM_STAT*DW-1:0] cp_status_i
);
  logic [WAW-1:0]         waddr;
  logic                   aligned;
  logic [DW-1:0]          args_q [NUM_ARGS];
  logic [NUM_ARGS*DW-1:0] args_flat;
  logic [DW-1:0]          ret_w;
  logic [NUM_STAT*DW-1:0] stat_w;
  logic [CW-1:0]          q_count;
  logic                   q_drop, q_full_set, q_done_ok, push;
  irq_vec_t               ev, wr_bits, flags, mask;
  logic [DW-1:0]          qstat_word, rd_mux, rdata_q;

  assign waddr   = addr_i[AW-1:2];
  assign aligned = addr_i[1:0] == 2'b00;
  assign push    = wr_i && aligned && (waddr == WAW'(W_CMD));

  for (genvar g = 0; g < NUM_ARGS; g++) begin : g_arg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) args_q[g] <= '0;
      else if (wr_i && aligned && waddr == WAW'(g)) args_q[g] <= wdata_i;
    end
    assign args_flat[g*DW +: DW] = args_q[g];
  end

  mbox_cmd_queue #(.DW(DW), .NUM_ARGS(NUM_ARGS), .DEPTH(DEPTH)) u_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .cmd_i       (wdata_i),
    .args_i      (args_flat),
    .pop_i       (cp_pop_i),
    .done_i      (cp_done_i),
    .count_o     (q_count),
    .drop_o      (q_drop),
    .full_set_o  (q_full_set),
    .done_ok_o   (q_done_ok),
    .head_valid_o(cp_cmd_valid_o),
    .head_cmd_o  (cp_cmd_o),
    .head_args_o (cp_args_o)
  );

  mbox_result_regs #(.DW(DW), .NUM_STAT(NUM_STAT)) u_result (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(q_done_ok),
    .ret_i (cp_retcode_i),
    .stat_i(cp_status_i),
    .ret_o (ret_w),
    .stat_o(stat_w)
  );

  assign ev.done      = q_done_ok;
  assign ev.drop      = q_drop;
  assign ev.full      = q_full_set;
  assign wr_bits.done = wdata_i[BIT_DONE];
  assign wr_bits.drop = wdata_i[BIT_DROP];
  assign wr_bits.full = wdata_i[BIT_FULL];

  mbox_irq_ctrl u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev),
    .clr_we_i (wr_i && aligned && waddr == WAW'(W_FLAGS)),
    .clr_i    (wr_bits),
    .mask_we_i(wr_i && aligned && waddr == WAW'(W_MASK)),
    .mask_i   (wr_bits),
    .flags_o  (flags),
    .mask_o   (mask),
    .irq_o    (irq_o)
  );

  always_comb begin
    qstat_word            = '0;
    qstat_word[CW-1:0]    = q_count;
    qstat_word[BIT_READY] = cp_ready_i;
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      for (int i = 0; i < NUM_ARGS; i++)
        if (waddr == WAW'(i)) rd_mux = args_q[i];
      for (int i = 0; i < NUM_STAT; i++)
        if (waddr == WAW'(W_STAT0 + i)) rd_mux = stat_w[i*DW +: DW];
      if (waddr == WAW'(W_RET))   rd_mux = ret_w;
      if (waddr == WAW'(W_QSTAT)) rd_mux = qstat_word;
      if (waddr == WAW'(W_FLAGS)) rd_mux = irq_to_word(flags);
      if (waddr == WAW'(W_MASK))  rd_mux = irq_to_word(mask);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end
  assign rdata_o = rdata_q;

  assert_valid_needs_entry_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_cmd_valid_o |-> q_count != '0);
  assert_arg_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == 8'h00) |=> args_q[0] == $past(wdata_i));
  assert_read_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: tb/cmd_mailbox_tb.sv
module cmd_mailbox_tb;
  import mbox_pkg::*;
  localparam int EW = (NUM_ARGS + 1) * DW;
  typedef logic [EW-1:0] ent_t;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic [7:0] addr_i;
  logic wr_i, rd_i, pop_i, done_i, ready_i;
  logic [31:0] wdata_i, rdata_o, cmd_o, retcode_i;
  logic irq_o, valid_o;
  logic [NUM_ARGS*DW-1:0] args_o;
  logic [NUM_STAT*DW-1:0] status_i;

  cmd_mailbox u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .cp_ready_i(ready_i),
    .cp_cmd_valid_o(valid_o), .cp_cmd_o(cmd_o), .cp_args_o(args_o),
    .cp_pop_i(pop_i), .cp_done_i(done_i), .cp_retcode_i(retcode_i),
    .cp_status_i(status_i)
  );

  ent_t        mq[$];
  int          issued, tests, fails;
  logic [31:0] m_args[16], m_stat[16], m_ret, m_flags, m_mask, m_rdata;
  bit          m_rdv;
  string       rd_tag, m_tag;

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(logic [7:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    if (a < 8'h40) return m_args[a[5:2]];
    if (a == 8'h80) return m_ret;
    if (a >= 8'h84 && a <= 8'hC0) return m_stat[(a - 8'h84) >> 2];
    if (a == 8'hC4) return {23'h0, ready_i, 5'h0, 3'(mq.size())};
    if (a == 8'hC8) return m_flags;
    if (a == 8'hCC) return m_mask;
    return 32'h0;
  endfunction

  // behavioural reference, stepped on every clock and compared after the edge
  always @(posedge clk) begin
    if (rst_n) begin
      bit done_ok, pop_ok, push, full;
      logic [31:0] ev;
      ent_t e;
      m_rdv = rd_i;
      if (rd_i) begin m_rdata = m_read(addr_i); m_tag = rd_tag; end
      done_ok = done_i && issued > 0;
      pop_ok  = pop_i && mq.size() > issued;
      push    = wr_i && addr_i == 8'h40;
      full    = mq.size() == 4;
      ev = 32'h0;
      if (done_ok) begin
        m_ret = retcode_i;
        for (int i = 0; i < 16; i++) m_stat[i] = status_i[i*32 +: 32];
        void'(mq.pop_front());
        issued--;
        ev[0] = 1'b1;
      end
      if (pop_ok) issued++;
      if (push) begin
        if (full) ev[17] = 1'b1;
        else begin
          e[31:0] = wdata_i;
          for (int i = 0; i < 16; i++) e[32 + i*32 +: 32] = m_args[i];
          mq.push_back(e);
          if (mq.size() == 4) ev[18] = 1'b1;
        end
      end
      if (wr_i && addr_i == 8'hC8) m_flags &= ~(wdata_i & 32'h0006_0001);
      m_flags |= ev;
      if (wr_i && addr_i == 8'hCC) m_mask = wdata_i & 32'h0006_0001;
      if (wr_i && addr_i[1:0] == 2'b00 && addr_i < 8'h40) m_args[addr_i[5:2]] = wdata_i;
      #2;
      chk(32'(irq_o), 32'(|(m_flags & ~m_mask)), "R8 irq level");
      chk(32'(valid_o), 32'(mq.size() > issued), "R2 cmd valid");
      if (valid_o && mq.size() > issued) begin
        e = mq[issued];
        chk(cmd_o, e[31:0], "R2 head command order");
        for (int i = 0; i < 16; i++)
          chk(args_o[i*32 +: 32], e[32 + i*32 +: 32], "R10 head argument snapshot");
      end
      if (m_rdv) chk(rdata_o, m_rdata, m_tag);
    end
  end

  task automatic op(bit w, bit r, logic [7:0] a, logic [31:0] d, bit p, bit dn, string tag);
    @(negedge clk);
    wr_i = w; rd_i = r; addr_i = a; wdata_i = d; pop_i = p; done_i = dn;
    if (r) rd_tag = tag;
  endtask
  task automatic wr(logic [7:0] a, logic [31:0] d); op(1, 0, a, d, 0, 0, ""); endtask
  task automatic rd(logic [7:0] a, string tag);     op(0, 1, a, 0, 0, 0, tag); endtask
  task automatic nop();                             op(0, 0, 8'h0, 0, 0, 0, ""); endtask
  task automatic set_result(int k);
    retcode_i = 32'hA500_0000 + k;
    for (int i = 0; i < 16; i++) status_i[i*32 +: 32] = 32'(k * 256 + i);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0; fails = 0; issued = 0; m_rdv = 0;
    m_ret = 0; m_flags = 0; m_mask = 32'h0006_0001; m_rdata = 0;
    for (int i = 0; i < 16; i++) begin m_args[i] = 0; m_stat[i] = 0; end
    rst_n = 0; wr_i = 0; rd_i = 0; pop_i = 0; done_i = 0; ready_i = 1;
    addr_i = 0; wdata_i = 0; retcode_i = 0; status_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    rd(8'hCC, "R8 mask reset");
    rd(8'hC8, "R7 flags reset");
    rd(8'hC4, "R3 queue status reset");
    rd(8'h3C, "R1 arg reset");
    // argument registers
    for (int i = 0; i < 16; i++) wr(8'(i * 4), 32'h1000_0000 + i);
    rd(8'h00, "R1 arg0"); rd(8'h24, "R1 arg9"); rd(8'h3C, "R1 arg15");
    // two commands with argument rewrite between them
    wr(8'h40, 32'hC0DE_0001);
    for (int i = 0; i < 16; i++) wr(8'(i * 4), 32'h2000_0000 + i);
    wr(8'h40, 32'hC0DE_0002);
    wr(8'h08, 32'hDEAD_BEEF);
    rd(8'hC4, "R3 count two");
    ready_i = 0;
    rd(8'hC4, "R3 ready low");
    ready_i = 1;
    // ignored completion before any pop
    set_result(7);
    op(0, 0, 0, 0, 0, 1, "");
    rd(8'hC4, "R11 done ignored count");
    rd(8'h80, "R11 done ignored result");
    op(0, 0, 0, 0, 1, 0, "");
    op(0, 0, 0, 0, 1, 0, "");
    op(0, 0, 0, 0, 1, 0, "");   // nothing left to pop
    rd(8'hC4, "R11 pop ignored count");
    set_result(1);
    op(0, 0, 0, 0, 0, 1, "");
    rd(8'h80, "R6 result code");
    rd(8'h84, "R6 status0"); rd(8'hC0, "R6 status15");
    rd(8'hC4, "R6 count after done");
    rd(8'hC8, "R6 done flag");
    set_result(2);
    op(0, 0, 0, 0, 0, 1, "");
    // unmask and clear
    wr(8'hCC, 32'h0006_0000);
    wr(8'hC8, 32'h0000_0001);
    rd(8'hC8, "R7 flag cleared");
    // fill the queue
    for (int k = 0; k < 4; k++) begin
      wr(8'h00, 32'h3000_0000 + k);
      wr(8'h40, 32'hC0DE_0010 + k);
    end
    rd(8'hC4, "R3 count four");
    rd(8'hC8, "R5 full flag");
    wr(8'hCC, 32'h0);
    wr(8'h40, 32'hBAD0_0000);
    rd(8'hC8, "R4 drop flag");
    rd(8'hC4, "R4 count unchanged");
    // overflow on same cycle as a completion
    op(0, 0, 0, 0, 1, 0, "");
    set_result(3);
    op(1, 0, 8'h40, 32'hBAD0_0001, 0, 1, "");
    rd(8'hC4, "R4 drop despite completion");
    // clear done in the cycle of a new completion: event wins
    op(0, 0, 0, 0, 1, 0, "");
    set_result(4);
    op(1, 0, 8'hC8, 32'h0006_0001, 0, 1, "");
    rd(8'hC8, "R7 set beats clear");
    // simultaneous pop and done
    op(0, 0, 0, 0, 1, 0, "");
    set_result(5);
    op(0, 0, 0, 0, 1, 1, "");
    rd(8'hC4, "R3 count after pop and done");
    // unmapped, unaligned, read-only writes
    rd(8'hF0, "R9 unmapped");
    rd(8'h81, "R9 unaligned");
    wr(8'h80, 32'hFFFF_FFFF);
    wr(8'hC4, 32'hFFFF_FFFF);
    rd(8'h80, "R9 read-only result");
    rd(8'hC4, "R9 read-only status");
    wr(8'hC8, 32'hFFFF_FFFF);
    wr(8'hCC, 32'hFFFF_FFFF);
    rd(8'hCC, "R8 mask bits only");
    rd(8'hC8, "R7 all cleared");
    nop(); nop(); nop();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule